// File: doc/BRIEF.md
# Transmit Cell Buffer with Idle-Cell Insertion

This block sits between the ATM layer and the payload mapper of a SONET/SDH transmit path. On the ATM-layer side it takes in cells one byte per clock over an 8-bit port. That port has a start-of-cell flag and an enable. The block holds up to four whole 53-byte cells. It signals the ATM layer to stop sending a few bytes before the store runs out. A cell that breaks off early because a new start-of-cell arrives is thrown away and recorded in a sticky error flag.

On the physical-layer side, the payload mapper asks for one byte per clock with a request strobe. The block answers every request with the next byte of an unbroken 53-byte cell stream, and it marks the first byte of each cell. At each cell boundary the block makes a choice. If a whole user cell is waiting, it sends that cell. Otherwise it sends a generated idle cell. The output therefore never stalls. The header-check byte position carries a fixed placeholder that a later stage overwrites. The two sides run on unrelated clocks, and only whole-cell pointers cross between them, in Gray code.

Top module: `tx_cell_buffer`

## Requirements
- R1: The buffer holds at most four complete cells. A start-of-cell that arrives while four cells are held is dropped together with the rest of its cell, and it sets `err_o`.
- R2: An input byte is taken at the rising edge of `wr_clk_i` only when `tx_en_i` is 1. While `tx_en_i` is 0, `tx_data_i` and `tx_soc_i` have no effect.
- R3: `tx_soc_i` = 1 marks byte 0 of a cell. Enabled bytes that arrive with no cell open (before any start-of-cell, or after a cell completes) are dropped without an error.
- R4: `full_o` is 1 exactly when free byte slots, counted as (4 − cells held) × 53 − bytes of the open cell, are 4 or fewer. It is 0 after reset and falls again once the read side frees a cell.
- R5: At each rising edge of `rd_clk_i` with `rd_req_i` = 1, `cell_data_o` and `cell_soc_o` present one new byte. `cell_soc_o` = 1 only on byte 0 of a cell, and the first byte after reset is a byte 0.
- R6: When no complete user cell is held at a cell boundary, an idle cell is sent. Its bytes 0 to 2 are 0x00, byte 3 is 0x01, byte 4 is 0x00, and bytes 5 to 52 are 0x6A.
- R7: User cells leave in arrival order. Every byte is unchanged except byte 4 (the header-check position), which is sent as 0x00.
- R8: The choice between user cell and idle cell is made only at byte 0. A cell once begun is always sent in full, so start-of-cell marks are exactly 53 requested bytes apart.
- R9: A start-of-cell arriving while a cell is partly received discards the partial cell and restarts with the new byte as byte 0. It sets `err_o`, which stays 1 until reset.
- R10: While `rd_req_i` is 0, `cell_data_o` and `cell_soc_o` hold their values.
- R11: During and right after reset, `full_o`, `err_o`, `cell_soc_o` and `cell_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | ATM-layer transmit clock |
| rd_clk_i | input | 1 | Physical-layer byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| tx_data_i | input | 8 | Cell byte from the ATM layer |
| tx_soc_i | input | 1 | First byte of a cell |
| tx_en_i | input | 1 | Input byte valid |
| full_o | output | 1 | Four or fewer free byte slots remain |
| err_o | output | 1 | Sticky: truncated cell or overflow start-of-cell seen |
| rd_req_i | input | 1 | Mapper requests the next byte |
| cell_data_o | output | 8 | Outgoing cell byte |
| cell_soc_o | output | 1 | Outgoing byte is byte 0 of a cell |

## Verification
A corrupted read pointer or byte counter shows up at the output within one cell time (53 requested bytes). It appears as misplaced start-of-cell marks, cells out of order, or bytes that match neither the stored cell nor the idle pattern. A wrong free-space count in the write domain moves the `full_o` edge off the 49th byte of the fourth held cell, which is visible on that very byte. Lost or extra pointer increments appear as dropped, repeated or extra user cells once the stream has drained into idle cells.

// File: rtl/txcb_pkg.sv
package txcb_pkg;
  localparam int unsigned HEC_POS      = 4;
  localparam int unsigned IDLE_MARK_POS = 3;
  localparam logic [7:0]  IDLE_MARK    = 8'h01;
  localparam logic [7:0]  IDLE_FILL    = 8'h6A;
  localparam logic [7:0]  HEC_FILL     = 8'h00;
endpackage

// File: rtl/txcb_ptr_cdc.sv
module txcb_ptr_cdc #(
  parameter int unsigned W = 3
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, meta_q, sync_q;

  always_ff @(posedge src_clk_i or negedge rst_ni)
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);

  always_ff @(posedge dst_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end

  for (genvar i = 0; i < W; i++) begin : g_bin
    assign bin_o[i] = ^(sync_q >> i);
  end
endmodule

// File: rtl/txcb_mem.sv
module txcb_mem #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txcb_wr_side.sv
module txcb_wr_side
  import txcb_pkg::*;
#(
  parameter int unsigned NUM_CELLS   = 4,
  parameter int unsigned CELL_BYTES  = 53,
  parameter int unsigned FULL_MARGIN = 4,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned CW = $clog2(NUM_CELLS),
  localparam int unsigned PW = CW + 1,
  localparam int unsigned OW = $clog2(CELL_BYTES),
  localparam int unsigned FW = $clog2(NUM_CELLS * CELL_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              soc_i,
  input  logic              en_i,
  input  logic [PW-1:0]     rd_ptr_i,
  output logic              we_o,
  output logic [CW+OW-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [PW-1:0]     wr_ptr_o,
  output logic              full_o,
  output logic              err_o
);
  logic [PW-1:0] wr_ptr_q, used;
  logic [OW-1:0] off_q, wr_off;
  logic          open_cell, slot_free, accept, last, err_q;
  logic [FW-1:0] free_bytes;

  always_comb begin
    used       = wr_ptr_q - rd_ptr_i;
    open_cell  = off_q != '0;
    slot_free  = used < PW'(NUM_CELLS);
    // a restart reuses the open slot; a fresh cell needs a free slot
    accept     = en_i && (open_cell || (soc_i && slot_free));
    wr_off     = soc_i ? '0 : off_q;
    last       = wr_off == OW'(CELL_BYTES - 1);
    free_bytes = FW'(PW'(NUM_CELLS) - used) * FW'(CELL_BYTES) - FW'(off_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      off_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (accept) begin
        if (last) begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
          off_q    <= '0;
        end else begin
          off_q <= wr_off + 1'b1;
        end
      end
      if (en_i && soc_i && (open_cell || !slot_free)) err_q <= 1'b1;
    end

  assign we_o     = accept;
  assign waddr_o  = {wr_ptr_q[CW-1:0], wr_off};
  assign wdata_o  = data_i;
  assign wr_ptr_o = wr_ptr_q;
  assign full_o   = free_bytes <= FW'(FULL_MARGIN);
  assign err_o    = err_q;
endmodule

// File: rtl/txcb_rd_side.sv
module txcb_rd_side
  import txcb_pkg::*;
#(
  parameter int unsigned NUM_CELLS  = 4,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned CW = $clog2(NUM_CELLS),
  localparam int unsigned PW = CW + 1,
  localparam int unsigned OW = $clog2(CELL_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [PW-1:0]     wr_ptr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [CW+OW-1:0]  raddr_o,
  output logic [PW-1:0]     rd_ptr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              soc_o
);
  logic [PW-1:0]     rd_ptr_q;
  logic [OW-1:0]     off_q;
  logic              user_q, use_user, at_start;
  logic [DATA_W-1:0] idle_byte, byte_n;

  always_comb begin
    at_start = off_q == '0;
    // user/idle choice is taken only at byte 0 and held for the cell
    use_user = at_start ? (rd_ptr_q != wr_ptr_i) : user_q;
    if (off_q < OW'(IDLE_MARK_POS))       idle_byte = '0;
    else if (off_q == OW'(IDLE_MARK_POS)) idle_byte = DATA_W'(IDLE_MARK);
    else                                  idle_byte = DATA_W'(IDLE_FILL);
    if (off_q == OW'(HEC_POS)) byte_n = DATA_W'(HEC_FILL);
    else if (use_user)         byte_n = rdata_i;
    else                       byte_n = idle_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      off_q    <= '0;
      user_q   <= 1'b0;
      data_o   <= '0;
      soc_o    <= 1'b0;
    end else if (req_i) begin
      data_o <= byte_n;
      soc_o  <= at_start;
      user_q <= use_user;
      if (off_q == OW'(CELL_BYTES - 1)) begin
        off_q <= '0;
        if (use_user) rd_ptr_q <= rd_ptr_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end

  assign raddr_o  = {rd_ptr_q[CW-1:0], off_q};
  assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/tx_cell_buffer.sv
module tx_cell_buffer #(
  parameter int unsigned NUM_CELLS   = 4,
  parameter int unsigned CELL_BYTES  = 53,
  parameter int unsigned FULL_MARGIN = 4,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_soc_i,
  input  logic              tx_en_i,
  output logic              full_o,
  output logic              err_o,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] cell_data_o,
  output logic              cell_soc_o
);
  localparam int unsigned CW = $clog2(NUM_CELLS);
  localparam int unsigned PW = CW + 1;
  localparam int unsigned OW = $clog2(CELL_BYTES);
  localparam int unsigned AW = CW + OW;

  logic              mem_we;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;
  logic [PW-1:0]     wr_ptr, rd_ptr, wr_ptr_rd, rd_ptr_wr;

  txcb_wr_side #(
    .NUM_CELLS(NUM_CELLS), .CELL_BYTES(CELL_BYTES),
    .FULL_MARGIN(FULL_MARGIN), .DATA_W(DATA_W)
  ) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni),
    .data_i(tx_data_i), .soc_i(tx_soc_i), .en_i(tx_en_i),
    .rd_ptr_i(rd_ptr_wr),
    .we_o(mem_we), .waddr_o(waddr), .wdata_o(wdata),
    .wr_ptr_o(wr_ptr), .full_o(full_o), .err_o(err_o)
  );

  txcb_mem #(.AW(AW), .DATA_W(DATA_W)) u_mem (
    .clk_i(wr_clk_i), .we_i(mem_we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  txcb_ptr_cdc #(.W(PW)) u_wr2rd (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni(rst_ni),
    .bin_i(wr_ptr), .bin_o(wr_ptr_rd)
  );

  txcb_ptr_cdc #(.W(PW)) u_rd2wr (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni(rst_ni),
    .bin_i(rd_ptr), .bin_o(rd_ptr_wr)
  );

  txcb_rd_side #(
    .NUM_CELLS(NUM_CELLS), .CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .req_i(rd_req_i),
    .wr_ptr_i(wr_ptr_rd), .rdata_i(rdata),
    .raddr_o(raddr), .rd_ptr_o(rd_ptr),
    .data_o(cell_data_o), .soc_o(cell_soc_o)
  );
endmodule

// File: rtl/txcb_checker.sv
module txcb_checker #(
  parameter int unsigned NUM_CELLS  = 4,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned PW = $clog2(NUM_CELLS) + 1
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              rd_req_i,
  input logic              cell_soc_o,
  input logic [DATA_W-1:0] cell_data_o,
  input logic              err_o,
  input logic [PW-1:0]     wr_ptr,
  input logic [PW-1:0]     rd_ptr,
  input logic [PW-1:0]     rd_ptr_at_wr
);
  logic       req_q, seen_q;
  logic [7:0] cnt_q;
  logic [PW-1:0] used_w;

  assign used_w = wr_ptr - rd_ptr_at_wr;

  always_ff @(posedge rd_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      req_q  <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q <= rd_req_i;
      if (req_q) begin
        if (cell_soc_o) begin
          cnt_q  <= '0;
          seen_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

  AST_SOC_STRIDE: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (req_q && cell_soc_o && seen_q) |-> cnt_q == 8'(CELL_BYTES - 1)); // R8
  AST_BODY_LEN: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (req_q && !cell_soc_o && seen_q) |-> cnt_q < 8'(CELL_BYTES - 1)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    used_w <= PW'(NUM_CELLS)); // R1
  AST_RD_PTR_STEP: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !$stable(rd_ptr) |-> rd_ptr == PW'($past(rd_ptr) + 1'b1)); // R7
  AST_ERR_STICKY: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $past(err_o) |-> err_o); // R9
  AST_HOLD_NO_REQ: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !$past(rd_req_i) |-> ($stable(cell_data_o) && $stable(cell_soc_o))); // R10
endmodule

bind tx_cell_buffer txcb_checker #(
  .NUM_CELLS(NUM_CELLS), .CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W)
) u_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .rd_req_i(rd_req_i), .cell_soc_o(cell_soc_o), .cell_data_o(cell_data_o),
  .err_o(err_o), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_at_wr(rd_ptr_wr)
);

// File: tb/tx_cell_buffer_tb.sv
`timescale 1ns/1ps
module tx_cell_buffer_tb;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_soc = 1'b0, tx_en = 1'b0, rd_req = 1'b0;
  logic       full, err, c_soc;
  logic [7:0] c_data;

  int n_checks = 0, n_err = 0;

  always #2   wr_clk = ~wr_clk;   // 250 MHz
  always #3.5 rd_clk = ~rd_clk;

  tx_cell_buffer u_dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_soc_i(tx_soc), .tx_en_i(tx_en),
    .full_o(full), .err_o(err),
    .rd_req_i(rd_req), .cell_data_o(c_data), .cell_soc_o(c_soc)
  );

  // {seed, gaps, length}
  localparam logic [15:0] VEC [6] = '{
    16'h10B5, 16'h2014, 16'h3035, 16'h4081, 16'h5035, 16'h60B5
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // output monitor
  logic       req_seen = 1'b0, mon_on = 1'b0;
  int         idx = 53, idle_cnt = 0;
  logic [7:0] cbuf [53];
  logic [7:0] got_q [$];

  function automatic logic [7:0] idle_exp(input int k);
    if (k < 3) return 8'h00;
    if (k == 3) return 8'h01;
    if (k == 4) return 8'h00;
    return 8'h6A;
  endfunction

  always @(posedge rd_clk) req_seen <= rd_req;

  always @(negedge rd_clk) begin
    if (mon_on && req_seen) begin
      if (c_soc) begin
        check(idx == 53, "R8 start-of-cell spacing", idx, 53);
        idx = 0;
      end else if (idx == 53) begin
        check(0, "R5 missing start-of-cell", idx, 0);
        idx = 0;
      end
      cbuf[idx] = c_data;
      idx++;
      if (idx == 53) begin
        bit ok = 1'b1;
        int bad_a = 0, bad_e = 0;
        if (cbuf[0] == 8'h00) begin
          idle_cnt++;
          for (int k = 0; k < 53; k++)
            if (cbuf[k] !== idle_exp(k)) begin
              ok = 0; bad_a = cbuf[k]; bad_e = idle_exp(k);
            end
          check(ok, "R6 idle cell content", bad_a, bad_e);
        end else begin
          for (int k = 0; k < 53; k++) begin
            logic [7:0] e;
            e = (k == 4) ? 8'h00 : 8'(cbuf[0] + k);
            if (cbuf[k] !== e) begin
              ok = 0; bad_a = cbuf[k]; bad_e = e;
            end
          end
          check(ok, "R7 user cell content", bad_a, bad_e);
          got_q.push_back(cbuf[0]);
        end
      end
    end
  end

  task automatic do_reset();
    mon_on = 0;
    rst_n = 0; tx_en = 0; tx_soc = 0; tx_data = '0;
    @(negedge rd_clk) rd_req = 0;
    repeat (3) @(negedge wr_clk);
    idx = 53; idle_cnt = 0; got_q.delete();
    mon_on = 1;
    rst_n = 1;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s);
    @(negedge wr_clk);
    tx_data = d; tx_soc = s; tx_en = 1;
  endtask

  task automatic send_gap();
    @(negedge wr_clk);
    tx_data = 8'hFF; tx_soc = 1; tx_en = 0;   // R2: must be ignored
  endtask

  task automatic stop_tx();
    @(negedge wr_clk);
    tx_en = 0; tx_soc = 0;
  endtask

  task automatic send_cell(input logic [7:0] seed, input int len, input bit gaps);
    for (int k = 0; k < len; k++) begin
      if (gaps && (k % 7 == 3)) send_gap();
      send_byte(8'(seed + k), k == 0);
    end
    stop_tx();
  endtask

  task automatic check_seq(input string tag, input logic [7:0] exp [4]);
    check(got_q.size() == 4, tag, got_q.size(), 4);
    for (int i = 0; i < 4; i++)
      if (i < got_q.size()) check(got_q[i] == exp[i], tag, got_q[i], exp[i]);
  endtask

  initial begin
    #200000;
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    // reset state (R11)
    #1;
    check(full == 0, "R11 full_o in reset", full, 0);
    check(err == 0, "R11 err_o in reset", err, 0);
    do_reset();
    repeat (4) @(negedge wr_clk);
    check(full == 0, "R11 full_o after reset", full, 0);
    check(err == 0, "R11 err_o after reset", err, 0);
    check(c_soc == 0, "R11 cell_soc_o after reset", c_soc, 0);
    check(c_data == 0, "R11 cell_data_o after reset", c_data, 0);

    // fill with the read side stalled
    send_cell(8'h11, 53, 0);
    send_cell(8'h22, 53, 0);
    send_cell(8'h33, 53, 0);
    @(negedge wr_clk);
    check(full == 0, "R4 full_o with one cell free", full, 0);
    for (int k = 0; k < 48; k++) send_byte(8'(8'h44 + k), k == 0);
    stop_tx();
    check(full == 0, "R4 full_o at five free bytes", full, 0);
    send_byte(8'(8'h44 + 48), 0);
    stop_tx();
    check(full == 1, "R4 full_o at four free bytes", full, 1);
    for (int k = 49; k < 53; k++) send_byte(8'(8'h44 + k), 0);
    stop_tx();
    check(full == 1, "R4 full_o with four cells held", full, 1);
    check(err == 0, "R1 no error before overflow", err, 0);
    send_cell(8'hE0, 53, 0);
    @(negedge wr_clk);
    check(err == 1, "R1 overflow start-of-cell flags error", err, 1);
    check(c_soc == 0 && c_data == 0, "R10 outputs hold without request", {c_soc, c_data}, 0);

    // drain
    @(negedge rd_clk) rd_req = 1;
    repeat (70) @(negedge rd_clk);
    check(full == 0, "R4 full_o falls after a cell is read", full, 0);
    repeat (300) @(negedge rd_clk);
    check_seq("R1 four stored cells in order", '{8'h11, 8'h22, 8'h33, 8'h44});
    check(idle_cnt > 0, "R6 idle cells once drained", idle_cnt, 1);

    // table-driven stream with the read side running
    do_reset();
    @(negedge rd_clk) rd_req = 1;
    for (int k = 0; k < 5; k++) send_byte(8'h77, 0);   // no cell open
    stop_tx();
    @(negedge wr_clk);
    check(err == 0, "R3 bytes before start-of-cell raise no error", err, 0);
    foreach (VEC[v]) begin
      send_cell(VEC[v][15:8], int'(VEC[v][6:0]), VEC[v][7]);
      if (v == 0) check(err == 0, "R9 no error after whole cell", err, 0);
      repeat (60) @(negedge wr_clk);
    end
    check(err == 1, "R9 truncated cell sets sticky error", err, 1);
    repeat (700) @(negedge rd_clk);
    check_seq("R3 R9 only whole cells forwarded", '{8'h10, 8'h30, 8'h50, 8'h60});
    if (got_q.size() > 0) check(got_q[0] == 8'h10, "R2 cell with disabled gaps intact", got_q[0], 8'h10);
    check(idle_cnt > 0, "R6 idle cells before first user cell", idle_cnt, 1);
    check(err == 1, "R9 error still set", err, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule